// File: doc/BRIEF.md
# Video Output Pixel Clock Oscillator

This block produces the output pixel-clock enable of a video standards converter. The reference is the recovered video clock of the front-end decoder, not a free-running crystal. A host writes a nominal phase step along with the raster geometry. The nominal step is the product of frame rate, lines per frame and pixel clocks per line, and the host computes it. The block scales that step by a programmable fixed-point coefficient. When the incoming video belongs to the nominal 30 Hz family, it also multiplies the step by exactly 1000/1001, so the output runs at 29.97 Hz. Without that correction the two rates would differ by 0.03 Hz, the phases would drift apart without end, and frame lock would be lost from time to time.

The scaled step drives a phase accumulator. Each accumulator overflow yields one pixel enable. A pixel and line counter built on those enables marks the output frames. A newly written step, or a change in the input rate family, takes effect only at the next output frame start, so the frequency never changes mid-frame. The output is locked to the input only when both sides run at 25 Hz or both run at 30 Hz. In that case each input frame-start pulse restarts the output raster and clears the accumulator phase. For every other pairing the output free-runs.

Top module: `vid_dto_top`

## Requirements
- R1: While reset is held, pix_ce_o, frame_start_o, sync_en_o, pix_o and line_o are all zero.
- R2: With in_rate_i = 2'b00 (25 Hz family), the active step is (cfg_nominal_i × cfg_coef_i) >> 12, truncated to 32 bits, and pix_ce_o pulses once per accumulator overflow. Over N reference cycles the pulse count is within one of floor(N × step / 2^32).
- R3: With in_rate_i = 2'b01 (30 Hz family), the active step is the R2 step × 1000/1001, rounded to the nearest integer. The pulse count over N cycles is within one of floor(N × step / 2^32).
- R4: sync_en_o is 1 one cycle after in_rate_i and out_rate_i are equal and both are 2'b00 or both are 2'b01, and 0 one cycle after any other pairing. Codes 2'b10 and 2'b11 denote other rates and never lock.
- R5: When sync_en_o is 1 and in_frame_start_i is high at a clock edge, the next cycle shows pix_o = 0, line_o = 0 and frame_start_o = 1. The accumulator phase restarts from zero.
- R6: When sync_en_o is 0, in_frame_start_i is ignored: the counters and frame_start_o do not react to it.
- R7: pix_o advances on each pixel enable and wraps to 0 after cfg_pix_per_line_i − 1, which advances line_o. line_o wraps to 0 after cfg_lines_i − 1. frame_start_o is 1 in the cycle that shows that wrap, together with the enable.
- R8: A written step takes effect only at the next output frame start. The only exception is when the active step is still zero after reset, in which case it loads at once.
- R9: An input frame start that falls on the same edge as a natural frame wrap yields one frame_start_o pulse and one restart. The raster then advances normally from pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock from the decoder's recovered video clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Host write strobe for all configuration words |
| cfg_nominal_i | input | 32 | Nominal phase step computed by the host |
| cfg_coef_i | input | 16 | Scale coefficient, 4.12 fixed point |
| cfg_pix_per_line_i | input | 12 | Pixel enables per output line |
| cfg_lines_i | input | 11 | Lines per output frame |
| in_rate_i | input | 2 | Input frame-rate family: 00 = 25 Hz, 01 = 30 Hz, others = other |
| out_rate_i | input | 2 | Output frame-rate family, same coding |
| in_frame_start_i | input | 1 | One-cycle pulse at each input frame start |
| pix_ce_o | output | 1 | Output pixel clock enable, one cycle per overflow |
| frame_start_o | output | 1 | One-cycle pulse at each output frame start |
| sync_en_o | output | 1 | Output is locked to input frame timing |
| pix_o | output | 12 | Current output pixel index within the line |
| line_o | output | 11 | Current output line index within the frame |

## Verification
Two events can land on the same edge: an input frame-start restart and the natural frame wrap of the output raster. Both also load a pending step. The bench first aligns the raster with a restart, then times a second input frame-start pulse to hit the exact edge on which the eighth overflow closes the frame. It then judges that frame_start_o rises once, that the counters read zero, and that the next enable moves the raster to pixel 1 after a phase that starts again from zero.

// File: rtl/vid_dto_pkg.sv
package vid_dto_pkg;

   typedef enum logic [1:0] {
      RATE_25    = 2'b00,
      RATE_30    = 2'b01,
      RATE_OTH_A = 2'b10,
      RATE_OTH_B = 2'b11
   } rate_e;

   // Locking is only meaningful between two identical, known families
   function automatic logic rate_lockable(rate_e a, rate_e b);
      return (a == b) && ((a == RATE_25) || (a == RATE_30));
   endfunction

endpackage

// File: rtl/dto_incr_calc.sv
module dto_incr_calc #(
   parameter int ACC_W      = 32,
   parameter int COEF_W     = 16,
   parameter int COEF_FRAC  = 12,
   parameter int CORR_FRAC  = 42,
   parameter bit ROUND_CORR = 1'b1
) (
   input  logic [ACC_W-1:0]  nom_i,
   input  logic [COEF_W-1:0] coef_i,
   input  logic              corr_en_i,
   output logic [ACC_W-1:0]  inc_o
);
   localparam int SW = ACC_W + COEF_W;
   localparam int CW = ACC_W + CORR_FRAC;
   localparam int KW = CORR_FRAC + 11;

   // 1000/1001 as an unsigned fraction with CORR_FRAC bits
   localparam logic [KW-1:0] ONE_SH = KW'(1) << CORR_FRAC;
   localparam logic [KW-1:0] K_WIDE = (ONE_SH * KW'(1000) + KW'(500)) / KW'(1001);
   localparam logic [CORR_FRAC-1:0] K_CORR = CORR_FRAC'(K_WIDE);

   logic [SW-1:0]    prod_scale;
   logic [ACC_W-1:0] scaled;
   logic [CW-1:0]    prod_corr;
   logic [CW-1:0]    rnd;
   logic [ACC_W-1:0] corrected;

   always_comb begin
      prod_scale = {{COEF_W{1'b0}}, nom_i} * {{ACC_W{1'b0}}, coef_i};
      scaled     = ACC_W'(prod_scale >> COEF_FRAC);
      prod_corr  = {{CORR_FRAC{1'b0}}, scaled} * {{ACC_W{1'b0}}, K_CORR};
   end

   generate
      if (ROUND_CORR) begin : g_round
         assign rnd = CW'(1) << (CORR_FRAC - 1);
      end else begin : g_trunc
         assign rnd = '0;
      end
   endgenerate

   always_comb begin
      corrected = ACC_W'((prod_corr + rnd) >> CORR_FRAC);
      inc_o     = corr_en_i ? corrected : scaled;
   end

endmodule

// File: rtl/dto_phase_acc.sv
module dto_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic [ACC_W-1:0] inc_i,
   output logic             carry_o,
   output logic             ce_o
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;

   always_comb {carry_o, sum} = {1'b0, acc_q} + {1'b0, inc_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_q <= '0;
         ce_o  <= 1'b0;
      end else begin
         acc_q <= clear_i ? '0 : sum;
         ce_o  <= carry_o;
      end
   end

endmodule

// File: rtl/dto_frame_timer.sv
module dto_frame_timer #(
   parameter int PIX_W  = 12,
   parameter int LINE_W = 11
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              step_i,
   input  logic              restart_i,
   input  logic [PIX_W-1:0]  ppl_i,
   input  logic [LINE_W-1:0] lines_i,
   output logic [PIX_W-1:0]  pix_o,
   output logic [LINE_W-1:0] line_o,
   output logic              wrap_o,
   output logic              frame_start_o
);
   logic last_pix, last_line;

   always_comb begin
      last_pix  = (pix_o  == ppl_i   - PIX_W'(1));
      last_line = (line_o == lines_i - LINE_W'(1));
      wrap_o    = step_i && last_pix && last_line;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pix_o         <= '0;
         line_o        <= '0;
         frame_start_o <= 1'b0;
      end else begin
         frame_start_o <= restart_i || wrap_o;
         if (restart_i) begin
            pix_o  <= '0;
            line_o <= '0;
         end else if (step_i) begin
            if (last_pix) begin
               pix_o  <= '0;
               line_o <= last_line ? '0 : line_o + LINE_W'(1);
            end else begin
               pix_o  <= pix_o + PIX_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/vid_dto_top.sv
module vid_dto_top
   import vid_dto_pkg::*;
#(
   parameter int ACC_W      = 32,
   parameter int COEF_W     = 16,
   parameter int COEF_FRAC  = 12,
   parameter int CORR_FRAC  = 42,
   parameter bit ROUND_CORR = 1'b1,
   parameter int PIX_W      = 12,
   parameter int LINE_W     = 11
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [ACC_W-1:0]  cfg_nominal_i,
   input  logic [COEF_W-1:0] cfg_coef_i,
   input  logic [PIX_W-1:0]  cfg_pix_per_line_i,
   input  logic [LINE_W-1:0] cfg_lines_i,
   input  logic [1:0]        in_rate_i,
   input  logic [1:0]        out_rate_i,
   input  logic              in_frame_start_i,
   output logic              pix_ce_o,
   output logic              frame_start_o,
   output logic              sync_en_o,
   output logic [PIX_W-1:0]  pix_o,
   output logic [LINE_W-1:0] line_o
);
   generate
      if (ACC_W < 8 || ACC_W > 48) begin : g_bad_acc
         $error("vid_dto_top: ACC_W out of range");
      end
      if (COEF_FRAC >= COEF_W) begin : g_bad_coef
         $error("vid_dto_top: COEF_FRAC must be below COEF_W");
      end
      if (CORR_FRAC < 24 || CORR_FRAC > 52) begin : g_bad_corr
         $error("vid_dto_top: CORR_FRAC out of range");
      end
      if (PIX_W < 2 || LINE_W < 2) begin : g_bad_cnt
         $error("vid_dto_top: counter widths too small");
      end
   endgenerate

   logic [ACC_W-1:0]  nom_q;
   logic [COEF_W-1:0] coef_q;
   logic [PIX_W-1:0]  ppl_q;
   logic [LINE_W-1:0] lines_q;
   logic [ACC_W-1:0]  inc_next;
   logic [ACC_W-1:0]  inc_active_q;
   logic              sync_q;
   logic              restart;
   logic              carry;
   logic              wrap;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         nom_q   <= '0;
         coef_q  <= '0;
         ppl_q   <= '0;
         lines_q <= '0;
      end else if (cfg_we_i) begin
         nom_q   <= cfg_nominal_i;
         coef_q  <= cfg_coef_i;
         ppl_q   <= cfg_pix_per_line_i;
         lines_q <= cfg_lines_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) sync_q <= 1'b0;
      else         sync_q <= rate_lockable(rate_e'(in_rate_i), rate_e'(out_rate_i));
   end

   assign sync_en_o = sync_q;
   assign restart   = sync_q && in_frame_start_i;

   dto_incr_calc #(
      .ACC_W(ACC_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
      .CORR_FRAC(CORR_FRAC), .ROUND_CORR(ROUND_CORR)
   ) u_incr (
      .nom_i     (nom_q),
      .coef_i    (coef_q),
      .corr_en_i (rate_e'(in_rate_i) == RATE_30),
      .inc_o     (inc_next)
   );

   // Step changes only on a frame boundary, or at once while still idle
   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         inc_active_q <= '0;
      else if (restart || wrap || (inc_active_q == '0))
         inc_active_q <= inc_next;
   end

   dto_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (restart),
      .inc_i   (inc_active_q),
      .carry_o (carry),
      .ce_o    (pix_ce_o)
   );

   dto_frame_timer #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_timer (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .step_i        (carry),
      .restart_i     (restart),
      .ppl_i         (ppl_q),
      .lines_i       (lines_q),
      .pix_o         (pix_o),
      .line_o        (line_o),
      .wrap_o        (wrap),
      .frame_start_o (frame_start_o)
   );

endmodule

// File: rtl/vid_dto_chk.sv
module vid_dto_chk #(
   parameter int ACC_W  = 32,
   parameter int PIX_W  = 12,
   parameter int LINE_W = 11
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [1:0]        in_rate_i,
   input logic [1:0]        out_rate_i,
   input logic              in_frame_start_i,
   input logic              sync_en_o,
   input logic              pix_ce_o,
   input logic              frame_start_o,
   input logic [PIX_W-1:0]  pix_o,
   input logic [LINE_W-1:0] line_o,
   input logic [ACC_W-1:0]  inc_active
);
   p_lock_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_rate_i == out_rate_i && !in_rate_i[1]) |=> sync_en_o);

   p_lock_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(in_rate_i == out_rate_i && !in_rate_i[1]) |=> !sync_en_o);

   p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_en_o && in_frame_start_i) |=> (frame_start_o && pix_o == '0 && line_o == '0));

   p_frame_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_o |-> (pix_o == '0 && line_o == '0));

   p_hold_raster_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pix_ce_o && !frame_start_o) |-> ($stable(pix_o) && $stable(line_o)));

   p_step_at_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_active != $past(inc_active)) |-> (frame_start_o || $past(inc_active) == '0));

endmodule

bind vid_dto_top vid_dto_chk #(.ACC_W(ACC_W), .PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
   .clk_i            (clk_i),
   .rst_ni           (rst_ni),
   .in_rate_i        (in_rate_i),
   .out_rate_i       (out_rate_i),
   .in_frame_start_i (in_frame_start_i),
   .sync_en_o        (sync_en_o),
   .pix_ce_o         (pix_ce_o),
   .frame_start_o    (frame_start_o),
   .pix_o            (pix_o),
   .line_o           (line_o),
   .inc_active       (inc_active_q)
);

// File: tb/tb_vid_dto_top.sv
`timescale 1ns/1ps
module tb_vid_dto_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_nom = '0;
   logic [15:0] cfg_coef = '0;
   logic [11:0] cfg_ppl = '0;
   logic [10:0] cfg_lines = '0;
   logic [1:0]  in_rate = 2'b00;
   logic [1:0]  out_rate = 2'b00;
   logic        in_fs = 1'b0;
   logic        pix_ce, fs, sync_en;
   logic [11:0] pix;
   logic [10:0] line;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;   // 125 MHz

   vid_dto_top dut (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_nominal_i(cfg_nom),
      .cfg_coef_i(cfg_coef), .cfg_pix_per_line_i(cfg_ppl), .cfg_lines_i(cfg_lines),
      .in_rate_i(in_rate), .out_rate_i(out_rate), .in_frame_start_i(in_fs),
      .pix_ce_o(pix_ce), .frame_start_o(fs), .sync_en_o(sync_en),
      .pix_o(pix), .line_o(line));

   task automatic tick();
      @(negedge clk);
      cyc++;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [31:0] nom, input logic [15:0] coef,
                            input logic [11:0] ppl, input logic [10:0] lines);
      cfg_nom = nom; cfg_coef = coef; cfg_ppl = ppl; cfg_lines = lines; cfg_we = 1'b1;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic wait_fs();
      do tick(); while (!fs);
   endtask

   task automatic t_reset();
      tick(); tick();
      chk(pix_ce == 0 && fs == 0, "R1", "enable/frame during reset", {pix_ce, fs}, 0);
      chk(sync_en == 0, "R1", "sync_en during reset", sync_en, 0);
      chk(pix == 0 && line == 0, "R1", "raster during reset", {pix, line}, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_lock_codes();
      logic [1:0] a [5] = '{2'b00, 2'b01, 2'b00, 2'b10, 2'b11};
      logic [1:0] b [5] = '{2'b00, 2'b01, 2'b01, 2'b10, 2'b11};
      bit         e [5] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
      for (int i = 0; i < 5; i++) begin
         in_rate = a[i]; out_rate = b[i];
         tick();
         chk(sync_en == e[i], "R4", "sync_en for rate pair", sync_en, e[i]);
      end
      in_rate = 2'b00; out_rate = 2'b00;
      tick();
   endtask

   // Sync restart aligned to a cycle where the accumulator sits at zero
   task automatic t_restart();
      do tick(); while (!pix_ce);
      in_fs = 1'b1;
      tick();
      in_fs = 1'b0;
      chk(fs == 1 && pix == 0 && line == 0, "R5", "raster after restart", {fs, pix, line}, {1'b1, 23'd0});
      tick();
      chk(pix_ce == 0, "R5", "no enable one cycle after restart", pix_ce, 0);
      tick();
      chk(pix_ce == 1, "R5", "enable two cycles after restart", pix_ce, 1);
   endtask

   // Raster after a restart: step 2^31 gives an enable every second cycle
   task automatic t_raster();
      do tick(); while (!pix_ce);
      in_fs = 1'b1;
      tick();
      in_fs = 1'b0;
      for (int i = 0; i < 10; i++) tick();
      chk(pix == 1 && line == 1, "R7", "pixel 1 line 1 after five enables", {pix, line}, {12'd1, 11'd1});
      chk(fs == 0, "R7", "no frame start mid-frame", fs, 0);
      for (int i = 0; i < 6; i++) tick();
      chk(fs == 1 && pix_ce == 1 && pix == 0 && line == 0, "R7", "wrap after eight enables",
          {fs, pix_ce, pix, line}, {2'b11, 23'd0});
   endtask

   task automatic t_ignore_unlocked();
      out_rate = 2'b01;
      tick(); tick();
      do tick(); while (!(pix_ce && pix == 2));
      in_fs = 1'b1;
      tick();
      in_fs = 1'b0;
      chk(pix == 2 && line <= 1, "R6", "pixel unchanged after ignored pulse", pix, 2);
      chk(fs == 0, "R6", "no frame start from ignored pulse", fs, 0);
      out_rate = 2'b00;
      tick(); tick();
   endtask

   task automatic t_coincide();
      int fs_cnt = 0;
      do tick(); while (!pix_ce);
      in_fs = 1'b1;
      tick();
      in_fs = 1'b0;
      for (int i = 0; i < 15; i++) tick();
      in_fs = 1'b1;           // lands on the edge that closes the frame
      tick();
      in_fs = 1'b0;
      chk(fs == 1 && pix == 0 && line == 0, "R9", "frame start at coincident edge", {fs, pix, line}, {1'b1, 23'd0});
      fs_cnt += int'(fs);
      tick(); fs_cnt += int'(fs);
      chk(pix == 0, "R9", "raster held at origin", pix, 0);
      tick(); fs_cnt += int'(fs);
      chk(pix == 1 && pix_ce == 1, "R9", "first enable after coincident restart", {pix_ce, pix}, {1'b1, 12'd1});
      tick(); fs_cnt += int'(fs);
      chk(fs_cnt == 1, "R9", "frame start pulses", fs_cnt, 1);
   endtask

   task automatic t_step_at_frame();
      int last = -1;
      bool_t: begin end
      begin
         bit seen = 0;
         int bad_before = 0, bad_after = 0, n_before = 0, n_after = 0;
         wait_fs();
         for (int i = 0; i < 4; i++) tick();
         write_cfg(32'h4000_0000, 16'd4096, 12'd4, 11'd2);
         last = cyc - 1;
         for (int i = 0; i < 60; i++) begin
            tick();
            if (pix_ce) begin
               if (last >= 0) begin
                  if (!seen) begin n_before++; if (cyc - last != 2) bad_before++; end
                  else       begin n_after++;  if (cyc - last != 4) bad_after++;  end
               end
               last = cyc;
            end
            if (fs) seen = 1;
         end
         chk(n_before >= 2 && bad_before == 0, "R8", "old step kept until frame start", bad_before, 0);
         chk(n_after >= 5 && bad_after == 0, "R8", "new step after frame start", bad_after, 0);
      end
   endtask

   task automatic t_rate(input logic [1:0] rate, input string req);
      localparam longint N = 40000;
      longint unsigned scaled, inc, exp_cnt;
      longint cnt = 0;
      in_rate = rate;
      write_cfg(32'h4000_3039, 16'd6144, 12'd4, 11'd2);
      wait_fs();
      wait_fs();
      scaled = ((64'h4000_3039 * 64'd6144) >> 12) & 64'hFFFF_FFFF;
      inc = (rate == 2'b01) ? (scaled * 1000 + 500) / 1001 : scaled;
      exp_cnt = (N * inc) >> 32;
      for (longint i = 0; i < N; i++) begin
         tick();
         if (pix_ce) cnt++;
      end
      chk(cnt >= longint'(exp_cnt) - 1 && cnt <= longint'(exp_cnt) + 1, req,
          "enable count over window", cnt, longint'(exp_cnt));
      in_rate = 2'b00;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_lock_codes();
      write_cfg(32'h8000_0000, 16'd4096, 12'd4, 11'd2);
      tick(); tick();
      t_restart();
      t_raster();
      t_ignore_unlocked();
      t_coincide();
      t_step_at_frame();
      t_rate(2'b00, "R2");
      t_rate(2'b01, "R3");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule